// File: doc/BRIEF.md
# Key-Guarded Watchdog and Interval Timer

This block is a watchdog and interval timer built around an 8-bit up-counter and an 8-bit control register. Both registers sit on a small register bus that blocks stray writes. A write takes effect only if it is a 16-bit access whose upper byte holds the key for the addressed register. The counter key is 0x5A and the control key is 0xA5. Every other write, of any size or key, leaves the registers as they were. Reads need no key.

The counter advances on a prescaled tick taken from the input clock, and the control register selects the prescale divisor. When the counter wraps from 0xFF to 0x00, the block does one of two things, set by the control register. In watchdog mode it asserts a reset request for a fixed number of cycles. In interval mode it raises an interrupt.

A separate wake input starts a clock-stabilization count after the chip leaves standby through an interrupt. The counter runs from its preset value, and on its wrap the block emits a one-cycle ready pulse and disables itself. It raises neither a reset request nor an interrupt.

Top module: `gwd_top`

## Requirements
- R1: A write with bus_size 1 (16-bit) to byte offset 0 and key 0x5A in wdata[15:8] loads wdata[7:0] into the counter.
- R2: A write with bus_size 1 to byte offset 4 and key 0xA5 in wdata[15:8] loads the control register. Its fields are bit 7 enable, bit 6 mode (1 watchdog, 0 interval), bit 5 overflow flag, and bits 2:0 clock select. Bits 4:3 always read 0.
- R3: A write of any size other than 1 (0 byte, 2 long), or with the wrong key for the addressed register, changes no register.
- R4: A read of any size loads bus_rdata at the next clock edge with the register value, zero-extended to 32 bits. An unmapped offset reads 0.
- R5: The counter changes only while enable is 1, apart from bus writes. The prescaler restarts whenever enable is 0, so the first increment comes 32·2^select cycles after enable is set.
- R6: The counter increments once every 32·2^select input clock cycles (select 0 gives 32, select 7 gives 4096).
- R7: A wrap from 0xFF to 0x00 sets the overflow flag. Writing 0 to bit 5 clears it, and writing 1 leaves it unchanged.
- R8: In interval mode the irq output is high while the overflow flag is set.
- R9: In watchdog mode a wrap drives rst_req high for exactly 16 cycles, starting at the edge of the wrap. irq stays low.
- R10: A wake pulse sets enable and starts a stabilization count. On the next wrap, ready pulses for one cycle and enable clears. The flag, rst_req and irq stay untouched.
- R11: After reset, both registers read 0 and rst_req, irq and ready are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 write, 0 read |
| bus_size | input | 2 | Access size: 0 byte, 1 16-bit, 2 32-bit |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data, key in bits 15:8 |
| bus_rdata | output | 32 | Registered read data |
| wake | input | 1 | Standby left by interrupt; starts stabilization |
| rst_req | output | 1 | Watchdog reset request |
| irq | output | 1 | Interval-timer interrupt |
| ready | output | 1 | One-cycle pulse when stabilization ends |

## Verification
The properties assume that wake never coincides with a bus write, and that no control write re-enables the timer in the same cycle as a stabilization wrap. They also assume wake is pulsed only while the timer is disabled. The stimulus meets these conditions in three ways. It drives a single bus access or wake pulse at a time and always writes the control register to 0 before reconfiguring. It preloads the counter near 0xFF so that wraps come at known cycles. It never lets a second wrap retrigger the reset request while it is still held.

// File: rtl/gwd_pkg.sv
package gwd_pkg;
  localparam logic [1:0] SIZE_BYTE = 2'd0;
  localparam logic [1:0] SIZE_WORD = 2'd1;
  localparam logic [1:0] SIZE_LONG = 2'd2;

  localparam logic [7:0] KEY_CNT  = 8'h5A;
  localparam logic [7:0] KEY_CTRL = 8'hA5;

  typedef struct packed {
    logic       run;
    logic       wdog;
    logic       ovf;
    logic [1:0] rsvd;
    logic [2:0] sel;
  } ctrl_t;

  localparam int SEL_W = 3;
endpackage

// File: rtl/gwd_regif.sv
module gwd_regif
  import gwd_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int CNT_OFS  = 0,
  parameter int CTRL_OFS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [1:0]        bus_size,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic [7:0]        cnt_val,
  input  logic [7:0]        ctrl_val,
  output logic              cnt_wr,
  output logic              ctrl_wr,
  output logic [7:0]        wr_byte,
  output logic [31:0]       bus_rdata
);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(CNT_OFS);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);

  logic hit_cnt, hit_ctrl, word_wr, rd_en;
  logic unused_hi;

  assign hit_cnt  = (bus_addr == A_CNT);
  assign hit_ctrl = (bus_addr == A_CTRL);
  assign word_wr  = bus_sel && bus_we && (bus_size == SIZE_WORD);
  assign rd_en    = bus_sel && !bus_we;

  assign cnt_wr  = word_wr && hit_cnt  && (bus_wdata[15:8] == KEY_CNT);
  assign ctrl_wr = word_wr && hit_ctrl && (bus_wdata[15:8] == KEY_CTRL);
  assign wr_byte = bus_wdata[7:0];
  assign unused_hi = ^bus_wdata[31:16];

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (rd_en) begin
      if (hit_cnt)       bus_rdata <= {24'd0, cnt_val};
      else if (hit_ctrl) bus_rdata <= {24'd0, ctrl_val};
      else               bus_rdata <= '0;
    end
  end
endmodule

// File: rtl/gwd_prescale.sv
module gwd_prescale #(
  parameter int BASE_SHIFT = 5,
  parameter int SEL_W      = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int NSEL  = 1 << SEL_W;
  localparam int PRE_W = BASE_SHIFT + NSEL - 1;
  localparam logic [PRE_W-1:0] ONE = {{(PRE_W-1){1'b0}}, 1'b1};

  logic [PRE_W-1:0] pre_q;
  logic [NSEL-1:0]  hit;

  always_ff @(posedge clk) begin
    if (rst || clr) pre_q <= '0;
    else            pre_q <= pre_q + ONE;
  end

  // one terminal-count tap per divisor choice
  for (genvar g = 0; g < NSEL; g++) begin : g_tap
    assign hit[g] = &pre_q[BASE_SHIFT+g-1:0];
  end

  assign tick = run && hit[sel];
endmodule

// File: rtl/gwd_core.sv
module gwd_core
  import gwd_pkg::*;
#(
  parameter int RST_HOLD = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cnt_wr,
  input  logic       ctrl_wr,
  input  logic [7:0] wr_byte,
  input  logic       tick,
  input  logic       wake,
  output logic [7:0] cnt_q,
  output ctrl_t      ctl_q,
  output logic       pre_clr,
  output logic       rst_req,
  output logic       irq,
  output logic       ready
);
  localparam int HOLD_W = $clog2(RST_HOLD + 1);
  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(RST_HOLD - 1);

  logic [7:0]        cnt_d;
  ctrl_t             ctl_d;
  logic              stab_q, stab_d;
  logic              wrap, hw_flag, wd_fire, rdy_d;
  logic [HOLD_W-1:0] hold_q;

  always_comb begin
    cnt_d   = cnt_q;
    ctl_d   = ctl_q;
    stab_d  = stab_q;
    wrap    = tick && (&cnt_q);
    hw_flag = wrap && !stab_q;
    wd_fire = hw_flag && ctl_q.wdog;
    rdy_d   = wrap && stab_q;

    if (tick) cnt_d = cnt_q + 8'd1;
    if (rdy_d) begin
      ctl_d.run = 1'b0;
      stab_d    = 1'b0;
    end
    if (hw_flag) ctl_d.ovf = 1'b1;

    if (cnt_wr) cnt_d = wr_byte;
    if (ctrl_wr) begin
      ctl_d.run  = wr_byte[7];
      ctl_d.wdog = wr_byte[6];
      ctl_d.ovf  = (ctl_q.ovf && wr_byte[5]) || hw_flag;
      ctl_d.rsvd = 2'b00;
      ctl_d.sel  = wr_byte[2:0];
    end

    if (wake) begin
      ctl_d.run = 1'b1;
      stab_d    = 1'b1;
    end
    if (!ctl_d.run) stab_d = 1'b0;
  end

  assign pre_clr = wake || !ctl_q.run;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      ctl_q  <= '0;
      stab_q <= 1'b0;
      irq    <= 1'b0;
      ready  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      ctl_q  <= ctl_d;
      stab_q <= stab_d;
      irq    <= ctl_d.ovf && !ctl_d.wdog;
      ready  <= rdy_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= '0;
      rst_req <= 1'b0;
    end else if (wd_fire) begin
      hold_q  <= HOLD_LAST;
      rst_req <= 1'b1;
    end else if (hold_q != '0) begin
      hold_q  <= hold_q - 1'b1;
    end else begin
      rst_req <= 1'b0;
    end
  end
endmodule

// File: rtl/gwd_top.sv
module gwd_top
  import gwd_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int CNT_OFS    = 0,
  parameter int CTRL_OFS   = 4,
  parameter int BASE_SHIFT = 5,
  parameter int RST_HOLD   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [1:0]        bus_size,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              wake,
  output logic              rst_req,
  output logic              irq,
  output logic              ready
);
  logic [7:0] cnt_val, ctrl_val, wr_byte;
  ctrl_t      ctl;
  logic       cnt_wr, ctrl_wr, tick, pre_clr;

  assign ctrl_val = ctl;

  gwd_regif #(.ADDR_W(ADDR_W), .CNT_OFS(CNT_OFS), .CTRL_OFS(CTRL_OFS)) u_regif (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .cnt_val(cnt_val), .ctrl_val(ctrl_val), .cnt_wr(cnt_wr),
    .ctrl_wr(ctrl_wr), .wr_byte(wr_byte), .bus_rdata(bus_rdata)
  );

  gwd_prescale #(.BASE_SHIFT(BASE_SHIFT), .SEL_W(SEL_W)) u_pre (
    .clk(clk), .rst(rst), .clr(pre_clr), .run(ctl.run),
    .sel(ctl.sel), .tick(tick)
  );

  gwd_core #(.RST_HOLD(RST_HOLD)) u_core (
    .clk(clk), .rst(rst), .cnt_wr(cnt_wr), .ctrl_wr(ctrl_wr),
    .wr_byte(wr_byte), .tick(tick), .wake(wake), .cnt_q(cnt_val),
    .ctl_q(ctl), .pre_clr(pre_clr), .rst_req(rst_req), .irq(irq),
    .ready(ready)
  );
endmodule

// File: rtl/gwd_chk.sv
module gwd_chk #(
  parameter int ADDR_W   = 4,
  parameter int CNT_OFS  = 0,
  parameter int CTRL_OFS = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [1:0]        bus_size,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              wake,
  input logic [7:0]        cnt_val,
  input logic [7:0]        ctrl_val,
  input logic [31:0]       bus_rdata,
  input logic              rst_req,
  input logic              ready
);
  logic unmapped;
  assign unmapped = (bus_addr != ADDR_W'(CNT_OFS)) && (bus_addr != ADDR_W'(CTRL_OFS));

  // R3
  bad_size_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_we && bus_size != 2'd1 && !ctrl_val[7] && !wake) |=> $stable(cnt_val));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_val[7] && !bus_sel && !wake) |=> $stable(cnt_val));

  // R4
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_we && unmapped) |=> (bus_rdata == 32'd0));

  // R7
  flag_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ctrl_val[5]) |-> $past(ctrl_val[7]));

  // R9
  wdog_mode_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_req) |-> $past(ctrl_val[6]));

  // R10
  ready_stop_chk: assert property (@(posedge clk) disable iff (rst)
    ready |-> (!ctrl_val[7] && !$rose(rst_req)));
endmodule

bind gwd_top gwd_chk #(.ADDR_W(ADDR_W), .CNT_OFS(CNT_OFS), .CTRL_OFS(CTRL_OFS)) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_size(bus_size), .bus_addr(bus_addr), .wake(wake),
  .cnt_val(cnt_val), .ctrl_val(ctrl_val), .bus_rdata(bus_rdata),
  .rst_req(rst_req), .ready(ready)
);

// File: tb/gwd_top_tb.sv
module gwd_top_tb;
  localparam int AW = 4;
  localparam logic [AW-1:0] A_CNT = 4'd0, A_CTRL = 4'd4;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_sel = 0, bus_we = 0, wake = 0;
  logic [1:0] bus_size = 0;
  logic [AW-1:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic rst_req, irq, ready;

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  gwd_top u_dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .wake(wake), .rst_req(rst_req), .irq(irq),
    .ready(ready)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compare read data against queued expectations
  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0) check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_size = sz; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [1:0] sz, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a; bus_size = sz;
    @(posedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic finish_run();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int hi_r, hi_i, hi_y;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 0;

    // R11 reset state
    check("R11 rst_req", {31'd0, rst_req}, 32'd0);
    check("R11 irq", {31'd0, irq}, 32'd0);
    check("R11 ready", {31'd0, ready}, 32'd0);
    rd(A_CNT, 2'd1, 32'h0, "R11 counter");
    rd(A_CTRL, 2'd1, 32'h0, "R11 control");

    // R1 keyed counter write
    wr(A_CNT, 2'd1, 32'h5A3C);
    rd(A_CNT, 2'd1, 32'h3C, "R1 counter load");

    // R3 rejected writes
    wr(A_CNT, 2'd1, 32'hA577);
    rd(A_CNT, 2'd1, 32'h3C, "R3 wrong key counter");
    wr(A_CNT, 2'd0, 32'h5A11);
    rd(A_CNT, 2'd1, 32'h3C, "R3 byte write");
    wr(A_CNT, 2'd2, 32'h5A22);
    rd(A_CNT, 2'd1, 32'h3C, "R3 long write");

    // R2 control write, reserved bits, R7 flag cannot be set by software
    wr(A_CTRL, 2'd1, 32'hA507);
    rd(A_CTRL, 2'd1, 32'h07, "R2 control load");
    wr(A_CTRL, 2'd1, 32'h5A03);
    rd(A_CTRL, 2'd1, 32'h07, "R3 wrong key control");
    wr(A_CTRL, 2'd1, 32'hA53F);
    rd(A_CTRL, 2'd1, 32'h07, "R2 R7 reserved and flag");

    // R4 read sizes and unmapped
    rd(4'd8, 2'd1, 32'h0, "R4 unmapped");
    rd(A_CNT, 2'd2, 32'h3C, "R4 long read");

    // R5 disabled counter holds
    wr(A_CTRL, 2'd1, 32'hA500);
    wr(A_CNT, 2'd1, 32'h5A40);
    repeat (300) @(negedge clk);
    rd(A_CNT, 2'd1, 32'h40, "R5 disabled hold");

    // R5 R6 divisor 32: read at 100 cycles after enable -> 3 ticks
    wr(A_CNT, 2'd1, 32'h5A10);
    wr(A_CTRL, 2'd1, 32'hA580);
    repeat (98) @(negedge clk);
    rd(A_CNT, 2'd1, 32'h13, "R6 divisor 32");
    wr(A_CTRL, 2'd1, 32'hA500);

    // R6 divisor 128: 300 cycles -> 2 ticks
    wr(A_CNT, 2'd1, 32'h5A00);
    wr(A_CTRL, 2'd1, 32'hA582);
    repeat (298) @(negedge clk);
    rd(A_CNT, 2'd1, 32'h02, "R6 divisor 128");
    wr(A_CTRL, 2'd1, 32'hA500);

    // R7 R8 interval overflow at 64 cycles
    wr(A_CNT, 2'd1, 32'h5AFE);
    wr(A_CTRL, 2'd1, 32'hA580);
    repeat (40) @(negedge clk);
    check("R8 irq before wrap", {31'd0, irq}, 32'd0);
    repeat (30) @(negedge clk);
    check("R8 irq after wrap", {31'd0, irq}, 32'd1);
    check("R8 no reset in interval", {31'd0, rst_req}, 32'd0);
    rd(A_CTRL, 2'd1, 32'hA0, "R7 flag set");
    wr(A_CTRL, 2'd1, 32'hA5A0);
    rd(A_CTRL, 2'd1, 32'hA0, "R7 write one keeps");
    wr(A_CTRL, 2'd1, 32'hA580);
    check("R8 irq cleared", {31'd0, irq}, 32'd0);
    rd(A_CTRL, 2'd1, 32'h80, "R7 flag cleared");
    wr(A_CTRL, 2'd1, 32'hA500);

    // R9 watchdog reset width
    wr(A_CNT, 2'd1, 32'h5AFF);
    wr(A_CTRL, 2'd1, 32'hA5C0);
    hi_r = 0; hi_i = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (rst_req) hi_r++;
      if (irq) hi_i++;
    end
    check("R9 reset width", hi_r, 16);
    check("R9 no irq", hi_i, 0);
    rd(A_CTRL, 2'd1, 32'hE0, "R9 flag in watchdog");
    wr(A_CTRL, 2'd1, 32'hA500);
    rd(A_CTRL, 2'd1, 32'h00, "R7 clear in watchdog");

    // R10 stabilization count, divisor 64, three ticks to wrap
    wr(A_CNT, 2'd1, 32'h5AFD);
    wr(A_CTRL, 2'd1, 32'hA541);
    @(negedge clk) wake = 1;
    @(posedge clk);
    @(negedge clk) wake = 0;
    hi_r = 0; hi_i = 0; hi_y = 0;
    for (int i = 0; i < 250; i++) begin
      @(negedge clk);
      if (rst_req) hi_r++;
      if (irq) hi_i++;
      if (ready) hi_y++;
    end
    check("R10 one ready pulse", hi_y, 1);
    check("R10 no reset", hi_r, 0);
    check("R10 no irq", hi_i, 0);
    rd(A_CTRL, 2'd1, 32'h41, "R10 enable cleared");
    rd(A_CNT, 2'd1, 32'h00, "R10 counter wrapped");
    repeat (100) @(negedge clk);
    rd(A_CNT, 2'd1, 32'h00, "R10 stopped");

    finish_run();
  end
endmodule